// File: doc/BRIEF.md
# Word-Serial Radix-4 Butterfly Engine

This block computes 4-point DFTs on a stream of complex samples that arrive one per clock. Accepted samples shift into a four-entry input bank. When the fourth sample of a group arrives, the whole group is copied in one step into a holding bank. The input bank is then free to collect the next group while the held group is being processed.

A 2-bit emission counter walks the held group through four butterfly outputs, one per cycle. In each cycle a swap stage rotates two of the operands by a power of −j. It does this by exchanging the real and imaginary parts and negating, with no multiplier. The rotated operands feed a tree of three pipelined complex add/subtract units that has no accumulation feedback. The counter's low bit selects add or subtract in the first level of the tree.

The result word is two bits wider than the input. This is exactly enough for every result of a full-scale input group. A sync flag sent with a sample forces that sample to be the first of a new group. Any partly collected group is dropped.

Top module: `r4_butterfly_engine`

## Requirements
- R1: A sample is accepted on a clock edge where `in_valid` is high. Accepted samples fill groups of four in arrival order, x0 first and x3 last.
- R2: A sample accepted with `in_sync` high becomes x0 of a new group. Samples accepted before it that did not complete a group produce no output. `in_sync` has no effect when `in_valid` is low.
- R3: The four results of a group leave in the order m = 0, 1, 2, 3. Result m equals x0 + (−j)^m·x1 + (−1)^m·x2 + (+j)^m·x3, computed exactly.
- R4: Multiplying by −j maps (re, im) to (im, −re), and multiplying by +j maps (re, im) to (−im, re). These rotations are applied before the add/subtract tree.
- R5: Result m = 0 of a group is valid 2 + 2·ADD_LAT clock cycles after the cycle in which the group's fourth sample is presented. With a gap-free input this is 5 + 2·ADD_LAT cycles after the first sample.
- R6: The four results of a group are valid on four consecutive cycles, and `out_valid` is low on every other cycle. Gap-free input gives one result every cycle with no bubbles.
- R7: Outputs are IN_W+2 bits wide, two's complement. No result overflows, including those of groups made only of the extreme values −2^(IN_W−1) and 2^(IN_W−1)−1.
- R8: While `rst_n` is low, and after release until a group completes, `out_valid` is low and the group position is at x0.
- R9: Cycles with `in_valid` low pause group collection without losing or reordering the samples already collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| in_valid | input | 1 | Input sample present this cycle |
| in_sync | input | 1 | Sample is the first of a new group (qualified by `in_valid`) |
| in_re | input | IN_W | Real part of input sample, signed |
| in_im | input | IN_W | Imaginary part of input sample, signed |
| out_valid | output | 1 | Butterfly result present this cycle |
| out_re | output | IN_W+2 | Real part of result, signed |
| out_im | output | IN_W+2 | Imaginary part of result, signed |

## Verification
The bench drives several kinds of group: single-lane impulses, which expose a wrong rotation sign or a swapped real/imaginary part in the swap stage; back-to-back groups, where an engine that reloads the holding bank one cycle early or late corrupts the last result or leaves a bubble; and groups broken by gaps or by a sync mid-group. A design that shifts the group boundary on a gap or ignores the sync would then emit results built from the wrong four samples. Groups made only of full-scale positive and most-negative values probe the output width: a result word one bit narrower, or a truncation at the wrong bit, wraps around at these values. An explicit latency measurement catches an extra or missing pipeline register.

// File: rtl/r4_pkg.sv
package r4_pkg;

  localparam int R4_POINTS = 4;

  // Rotation applied to an operand lane, indexed by the result index m:
  // the lane is multiplied by (-j)^m.
  typedef enum logic [1:0] {
    ROT_ONE   = 2'd0,
    ROT_NEG_J = 2'd1,
    ROT_MINUS = 2'd2,
    ROT_POS_J = 2'd3
  } rot_e;

endpackage

// File: rtl/r4_collect.sv
// Input side: shift bank filling groups of four, plus the holding bank that
// captures a complete group in parallel.
module r4_collect #(
  parameter int W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sync,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic                tup_ld,
  output logic signed [W-1:0] hold_re [r4_pkg::R4_POINTS],
  output logic signed [W-1:0] hold_im [r4_pkg::R4_POINTS]
);
  import r4_pkg::*;

  localparam int NPT = R4_POINTS;
  localparam int PW  = $clog2(NPT);
  localparam logic [PW-1:0] LAST_POS = PW'(NPT - 1);

  logic [PW-1:0]       pos_q, pos_d, pos_eff;
  logic signed [W-1:0] sh_re_q [NPT];
  logic signed [W-1:0] sh_im_q [NPT];

  // next-state: sync forces this sample to slot 0
  always_comb begin
    pos_eff = in_sync ? '0 : pos_q;
    tup_ld  = in_valid && (pos_eff == LAST_POS);
    pos_d   = in_valid ? pos_eff + PW'(1) : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // shift bank: newest sample enters at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPT; i++) begin
        sh_re_q[i] <= '0;
        sh_im_q[i] <= '0;
      end
    end else if (in_valid) begin
      for (int i = 0; i < NPT - 1; i++) begin
        sh_re_q[i] <= sh_re_q[i+1];
        sh_im_q[i] <= sh_im_q[i+1];
      end
      sh_re_q[NPT-1] <= in_re;
      sh_im_q[NPT-1] <= in_im;
    end
  end

  // holding bank: parallel copy of the completed group
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPT; i++) begin
        hold_re[i] <= '0;
        hold_im[i] <= '0;
      end
    end else if (tup_ld) begin
      for (int i = 0; i < NPT - 1; i++) begin
        hold_re[i] <= sh_re_q[i+1];
        hold_im[i] <= sh_im_q[i+1];
      end
      hold_re[NPT-1] <= in_re;
      hold_im[NPT-1] <= in_im;
    end
  end

  // R2: a synced sample always leaves the position just after slot 0
  a_r2_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sync) |=> (pos_q == PW'(1)));

  // R9: an idle cycle leaves the group position untouched
  a_r9_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q));

endmodule

// File: rtl/r4_sequencer.sv
// 2-bit emission counter plus the swap stage: it selects the result index,
// rotates lanes 1 and 3 by (-j)^m and registers the operand set.
module r4_sequencer #(
  parameter int W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tup_ld,
  input  logic signed [W-1:0] hold_re [r4_pkg::R4_POINTS],
  input  logic signed [W-1:0] hold_im [r4_pkg::R4_POINTS],
  output logic                op_vld,
  output logic                op_sub,
  output logic signed [W:0]   op_re [r4_pkg::R4_POINTS],
  output logic signed [W:0]   op_im [r4_pkg::R4_POINTS]
);
  import r4_pkg::*;

  localparam int NPT = R4_POINTS;
  localparam int CW  = $clog2(NPT);
  localparam logic [CW-1:0] LAST_IDX = CW'(NPT - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] idx_q, idx_d;
  logic signed [W:0] nx_re [NPT];
  logic signed [W:0] nx_im [NPT];

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (tup_ld) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      busy_d = (idx_q != LAST_IDX);
      idx_d  = idx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  // swap stage: odd lanes are rotated, even lanes only sign-extended
  for (genvar g = 0; g < NPT; g++) begin : g_lane
    logic signed [W:0] xr, xi;
    assign xr = {hold_re[g][W-1], hold_re[g]};
    assign xi = {hold_im[g][W-1], hold_im[g]};
    if (g % 2 == 1) begin : g_rot
      always_comb begin
        case (rot_e'(idx_q))
          ROT_NEG_J: begin nx_re[g] =  xi; nx_im[g] = -xr; end
          ROT_MINUS: begin nx_re[g] = -xr; nx_im[g] = -xi; end
          ROT_POS_J: begin nx_re[g] = -xi; nx_im[g] =  xr; end
          default:   begin nx_re[g] =  xr; nx_im[g] =  xi; end
        endcase
      end
    end else begin : g_pass
      assign nx_re[g] = xr;
      assign nx_im[g] = xi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_vld <= 1'b0;
      op_sub <= 1'b0;
    end else begin
      op_vld <= busy_q;
      op_sub <= busy_q && idx_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPT; i++) begin
        op_re[i] <= '0;
        op_im[i] <= '0;
      end
    end else if (busy_q) begin
      for (int i = 0; i < NPT; i++) begin
        op_re[i] <= nx_re[i];
        op_im[i] <= nx_im[i];
      end
    end
  end

  // R6: a new group never arrives before the previous one has fully left
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    tup_ld |-> (!busy_q || idx_q == LAST_IDX));

  // R3: results are stepped through in increasing index order
  a_r3_index_order: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tup_ld && idx_q != LAST_IDX) |=>
      (busy_q && idx_q == $past(idx_q) + CW'(1)));

endmodule

// File: rtl/r4_addsub.sv
// Complex add/subtract unit followed by a LAT-deep register pipeline.
module r4_addsub #(
  parameter int W   = 15,
  parameter int LAT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic                in_sub,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic                o_vld,
  output logic signed [W:0]   o_re,
  output logic signed [W:0]   o_im
);

  localparam int OW = W + 1;

  logic signed [OW-1:0] ax_re, ax_im, bx_re, bx_im, r_re, r_im;
  logic                 st_vld [LAT];
  logic signed [OW-1:0] st_re  [LAT];
  logic signed [OW-1:0] st_im  [LAT];

  always_comb begin
    ax_re = {a_re[W-1], a_re};
    ax_im = {a_im[W-1], a_im};
    bx_re = {b_re[W-1], b_re};
    bx_im = {b_im[W-1], b_im};
    r_re  = in_sub ? ax_re - bx_re : ax_re + bx_re;
    r_im  = in_sub ? ax_im - bx_im : ax_im + bx_im;
  end

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    logic                 d_vld;
    logic signed [OW-1:0] d_re, d_im;
    if (g == 0) begin : g_head
      assign d_vld = in_vld;
      assign d_re  = r_re;
      assign d_im  = r_im;
    end else begin : g_body
      assign d_vld = st_vld[g-1];
      assign d_re  = st_re[g-1];
      assign d_im  = st_im[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_vld[g] <= 1'b0;
      else        st_vld[g] <= d_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_re[g] <= '0;
        st_im[g] <= '0;
      end else if (d_vld) begin
        st_re[g] <= d_re;
        st_im[g] <= d_im;
      end
    end
  end

  assign o_vld = st_vld[LAT-1];
  assign o_re  = st_re[LAT-1];
  assign o_im  = st_im[LAT-1];

endmodule

// File: rtl/r4_butterfly_engine.sv
// Top: collect -> sequence/swap -> two-level add/sub tree.
module r4_butterfly_engine #(
  parameter int IN_W    = 14,
  parameter int ADD_LAT = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sync,
  input  logic signed [IN_W-1:0] in_re,
  input  logic signed [IN_W-1:0] in_im,
  output logic                   out_valid,
  output logic signed [IN_W+1:0] out_re,
  output logic signed [IN_W+1:0] out_im
);
  import r4_pkg::*;

  localparam int NPT   = R4_POINTS;
  localparam int OP_W  = IN_W + 1;   // after swap
  localparam int L1_W  = IN_W + 2;   // after first tree level
  localparam int L2_W  = IN_W + 3;   // raw second level
  localparam int OUT_W = IN_W + 2;

  logic                   tup_ld;
  logic signed [IN_W-1:0] hold_re [NPT];
  logic signed [IN_W-1:0] hold_im [NPT];
  logic                   op_vld, op_sub;
  logic signed [OP_W-1:0] op_re [NPT];
  logic signed [OP_W-1:0] op_im [NPT];
  logic                   u_vld, v_vld, w_vld;
  logic signed [L1_W-1:0] u_re, u_im, v_re, v_im;
  logic signed [L2_W-1:0] w_re, w_im;

  r4_collect #(.W(IN_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sync  (in_sync),
    .in_re    (in_re),
    .in_im    (in_im),
    .tup_ld   (tup_ld),
    .hold_re  (hold_re),
    .hold_im  (hold_im)
  );

  r4_sequencer #(.W(IN_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tup_ld  (tup_ld),
    .hold_re (hold_re),
    .hold_im (hold_im),
    .op_vld  (op_vld),
    .op_sub  (op_sub),
    .op_re   (op_re),
    .op_im   (op_im)
  );

  // first level, even lanes: x0 +/- x2
  r4_addsub #(.W(OP_W), .LAT(ADD_LAT)) u_even (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (op_vld),
    .in_sub (op_sub),
    .a_re   (op_re[0]),
    .a_im   (op_im[0]),
    .b_re   (op_re[2]),
    .b_im   (op_im[2]),
    .o_vld  (u_vld),
    .o_re   (u_re),
    .o_im   (u_im)
  );

  // first level, rotated odd lanes: r1 +/- r3
  r4_addsub #(.W(OP_W), .LAT(ADD_LAT)) u_odd (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (op_vld),
    .in_sub (op_sub),
    .a_re   (op_re[1]),
    .a_im   (op_im[1]),
    .b_re   (op_re[3]),
    .b_im   (op_im[3]),
    .o_vld  (v_vld),
    .o_re   (v_re),
    .o_im   (v_im)
  );

  // second level: always an addition
  r4_addsub #(.W(L1_W), .LAT(ADD_LAT)) u_final (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (u_vld),
    .in_sub (1'b0),
    .a_re   (u_re),
    .a_im   (u_im),
    .b_re   (v_re),
    .b_im   (v_im),
    .o_vld  (w_vld),
    .o_re   (w_re),
    .o_im   (w_im)
  );

  assign out_valid = w_vld;
  assign out_re    = w_re[OUT_W-1:0];
  assign out_im    = w_im[OUT_W-1:0];

  // R6: both first-level lanes stay cycle-aligned
  a_r6_lanes_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    u_vld == v_vld);

  // R7: dropping the top bit of the raw sum never changes its value
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    w_vld |-> (w_re[L2_W-1] == w_re[OUT_W-1] && w_im[L2_W-1] == w_im[OUT_W-1]));

  // R6: a burst of results is never a single cycle long
  a_r6_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid);

endmodule

// File: tb/r4_butterfly_engine_tb_top.sv
module r4_butterfly_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W       = 14;
  localparam int LAT        = 5;
  localparam int OUT_W      = IN_W + 2;
  localparam int PMAX       = (1 << (IN_W - 1)) - 1;
  localparam int NMIN       = -(1 << (IN_W - 1));

  logic clk   = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0;
  logic in_sync  = 1'b0;
  logic signed [IN_W-1:0]  in_re = '0;
  logic signed [IN_W-1:0]  in_im = '0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_re, out_im;

  r4_butterfly_engine #(.IN_W(IN_W), .ADD_LAT(LAT)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    edge_n = 0;
  bit    monitor_on = 1'b0;
  string cur_req = "R8";
  int    q_re[$];
  int    q_im[$];
  int    exp_re[int];
  int    exp_im[int];

  // multiply (re,im) by (-j)^m
  function automatic void rot_negj(input int re, input int im, input int m,
                                   output int ore, output int oim);
    case (m % 4)
      0: begin ore =  re; oim =  im; end
      1: begin ore =  im; oim = -re; end
      2: begin ore = -re; oim = -im; end
      default: begin ore = -im; oim = re; end
    endcase
  endfunction

  // reference model: groups of four, results scheduled by edge number
  always @(posedge clk) begin
    edge_n++;
    if (!rst_n) begin
      q_re.delete();
      q_im.delete();
    end else if (in_valid) begin
      if (in_sync) begin
        q_re.delete();
        q_im.delete();
      end
      q_re.push_back(int'(in_re));
      q_im.push_back(int'(in_im));
      if (q_re.size() == 4) begin
        for (int m = 0; m < 4; m++) begin
          int sr, si, tr, ti;
          sr = 0; si = 0;
          for (int n = 0; n < 4; n++) begin
            rot_negj(q_re[n], q_im[n], (n * m) % 4, tr, ti);
            sr += tr;
            si += ti;
          end
          exp_re[edge_n + 1 + 2 * LAT + m] = sr;
          exp_im[edge_n + 1 + 2 * LAT + m] = si;
        end
        q_re.delete();
        q_im.delete();
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (monitor_on) begin
      bit ev;
      int er, ei;
      ev = exp_re.exists(edge_n);
      er = ev ? exp_re[edge_n] : 0;
      ei = ev ? exp_im[edge_n] : 0;
      n_chk++;
      if (out_valid !== ev) begin
        n_bad++;
        $display("FAIL %s: edge %0d out_valid actual=%0b expected=%0b",
                 cur_req, edge_n, out_valid, ev);
      end else if (ev && (int'(out_re) != er || int'(out_im) != ei)) begin
        n_bad++;
        $display("FAIL %s: edge %0d result actual=(%0d,%0d) expected=(%0d,%0d)",
                 cur_req, edge_n, out_re, out_im, er, ei);
      end
      if (ev) begin
        exp_re.delete(edge_n);
        exp_im.delete(edge_n);
      end
    end
  end

  task automatic drive(input bit v, input bit s, input int re, input int im);
    @(negedge clk);
    in_valid = v;
    in_sync  = s;
    in_re    = IN_W'(re);
    in_im    = IN_W'(im);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0, 0);
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(2 * PMAX + 1)) + NMIN;
  endfunction

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic check_eq(input string req, input string what,
                          input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R6: watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    // R8: reset state
    repeat (3) @(negedge clk);
    check_eq("R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    idle(6);

    // R3 R4: single-lane impulses expose rotation and order
    cur_req = "R3 R4";
    for (int lane = 0; lane < 4; lane++) begin
      for (int n = 0; n < 4; n++)
        drive(1'b1, n == 0, (n == lane) ? 3 : 0, (n == lane) ? -5 : 0);
      idle(3);
    end
    for (int t = 0; t < 4; t++)
      for (int n = 0; n < 4; n++)
        drive(1'b1, n == 0, rnd_sample(), rnd_sample());
    idle(2 * LAT + 8);

    // R5: explicit latency from the fourth sample
    cur_req = "R5";
    begin
      int e4;
      for (int n = 0; n < 4; n++) drive(1'b1, n == 0, n + 1, 7 - n);
      drive(1'b0, 1'b0, 0, 0);
      e4 = edge_n;
      for (int w = 0; w < 4 * LAT + 10 && !out_valid; w++) @(negedge clk);
      check_eq("R5", "edges from fourth sample to first result",
               edge_n - e4, 1 + 2 * LAT);
    end
    idle(2 * LAT + 8);

    // R6: gap-free stream of groups
    cur_req = "R6";
    for (int t = 0; t < 40; t++)
      for (int n = 0; n < 4; n++)
        drive(1'b1, (t == 0 && n == 0), rnd_sample(), rnd_sample());
    idle(2 * LAT + 8);

    // R2: sync mid-group discards partial data; sync without valid ignored
    cur_req = "R2";
    drive(1'b1, 1'b1, 100, 1);
    drive(1'b1, 1'b0, 200, 2);
    drive(1'b0, 1'b1, 999, 9);
    drive(1'b1, 1'b1, 11, -3);
    for (int n = 1; n < 4; n++) drive(1'b1, 1'b0, rnd_sample(), rnd_sample());
    for (int n = 0; n < 3; n++) drive(1'b1, n == 0, rnd_sample(), rnd_sample());
    for (int n = 0; n < 4; n++) drive(1'b1, n == 0, rnd_sample(), rnd_sample());
    idle(2 * LAT + 8);

    // R9 R1: random gaps inside and between groups
    cur_req = "R9 R1";
    drive(1'b1, 1'b1, rnd_sample(), rnd_sample());
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(1) == 1) drive(1'b1, 1'b0, rnd_sample(), rnd_sample());
      else                        drive(1'b0, 1'b0, 0, 0);
    end
    idle(2 * LAT + 8);

    // R7: extreme values only
    cur_req = "R7";
    for (int n = 0; n < 4; n++) drive(1'b1, n == 0, PMAX, PMAX);
    for (int n = 0; n < 4; n++) drive(1'b1, 1'b0, NMIN, NMIN);
    for (int n = 0; n < 4; n++)
      drive(1'b1, 1'b0, (n % 2 == 0) ? PMAX : NMIN, (n < 2) ? NMIN : PMAX);
    for (int t = 0; t < 30; t++)
      for (int n = 0; n < 4; n++)
        drive(1'b1, 1'b0, ($urandom_range(1) == 1) ? PMAX : NMIN,
                          ($urandom_range(1) == 1) ? PMAX : NMIN);
    idle(2 * LAT + 8);

    monitor_on = 1'b0;
    check_eq("R6", "results left unemitted", exp_re.size(), 0);
    report();
    $finish;
  end

endmodule